// File: doc/BRIEF.md
# Washing Machine Fault Supervisor

This block sits beside the program sequencer of a washing machine and watches the active phase, the water sensors, a drum-bump switch and a slow timing tick. It cuts the machine's power when a fault appears. The faults it recognises are an external alarm, an inlet supply that runs dry while filling, a fill or a drain that takes too long, and the drum striking the tub while spinning. When a program ends normally, it sounds a completion chime for a fixed number of ticks and then switches the power off with no fault recorded.

A single trip latch drives the power-off line and holds a 3-bit fault code. Nothing clears either one except reset. The fill and drain time limits, and the chime length, are parameters counted in ticks. Each limit counter runs only while its own phase is active and restarts whenever that phase is entered again.

Top module: `wash_fault_guard`

## Requirements
- R1: A high `alarm_i` in any phase, idle included, sets `power_off_o` at the next clock edge with fault code 1.
- R2: In the fill phase (`phase_i` = 1), a low `supply_ok_i` trips at the next edge with fault code 2.
- R3: The fill limit works as follows. On the FILL_TICKS-th `tick_i` seen at a clock edge while `phase_i` = 1, or any later tick still in that phase, a low `level_hi_i` trips with fault code 3. Ticks outside fill do not count, and leaving fill restarts the count.
- R4: The drain limit works as follows. On the DRAIN_TICKS-th tick while `phase_i` = 4, or any later tick still in that phase, a high `level_hi_i` (water not yet drained) trips with fault code 4. The count restarts when drain is left.
- R5: In the spin phase (`phase_i` = 5), a high `bump_i` trips with fault code 5. Outside spin, `bump_i` has no effect.
- R6: A low `supply_ok_i` outside the fill phase has no effect.
- R7: In the done phase (`phase_i` = 6), `chime_o` is high while no trip is latched. On the CHIME_TICKS-th tick (default 20) in that phase, `power_off_o` rises at that edge with fault code 0, and `chime_o` falls at the same edge.
- R8: When several trip causes arrive in the same cycle, exactly one code is recorded. The order is alarm (1), then no water (2), then fill timeout (3), then drain timeout (4), then drum bump (5), with normal completion (0) last.
- R9: Once tripped, `power_off_o` stays high and `fault_o` keeps its value until reset, whatever the inputs do. `chime_o` stays low.
- R10: During reset and after its release, `power_off_o` is 0, `fault_o` is 0 and `chime_o` is 0. Reset is active-low and asynchronous, and its release is synchronised over two clock edges.
- R11: The `phase_i` codes 0 (idle), 2 (soak), 3 (wash) and 7 (spare) react only to the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_i | input | 3 | Sequencer phase: 0 idle, 1 fill, 2 soak, 3 wash, 4 drain, 5 spin, 6 done, 7 spare |
| tick_i | input | 1 | One-cycle phase-time tick |
| level_hi_i | input | 1 | Tub water at or above the fill level |
| supply_ok_i | input | 1 | Water present at the inlet |
| bump_i | input | 1 | Drum-to-tub contact switch |
| alarm_i | input | 1 | External alarm |
| power_off_o | output | 1 | Latched power cutoff |
| fault_o | output | 3 | Latched fault code (0 none or normal end) |
| chime_o | output | 1 | Completion chime request |

## Verification
The hardest situations to reach are the exact tick boundaries of the two timeouts and the restart of a limit counter when its phase is left and entered again. Random phases rarely stay long enough, and they rarely run without an early dry-supply or alarm trip. Directed sequences therefore hold fill or drain with the supply good and the level wrong. They stop one tick short of the limit, leave and return to show that the count restarts, and then run to the limit. Further directed cycles raise two causes at once to test the priority order. Randomised phase runs, checked against a bench model of the requirements, cover the remaining combinations.

// File: rtl/wg_pkg.sv
package wg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FILL  = 3'd1,
    PH_SOAK  = 3'd2,
    PH_WASH  = 3'd3,
    PH_DRAIN = 3'd4,
    PH_SPIN  = 3'd5,
    PH_DONE  = 3'd6,
    PH_SPARE = 3'd7
  } phase_e;

  typedef enum logic [2:0] {
    FC_NONE     = 3'd0,
    FC_ALARM    = 3'd1,
    FC_DRY      = 3'd2,
    FC_FILL_TO  = 3'd3,
    FC_DRAIN_TO = 3'd4,
    FC_BUMP     = 3'd5
  } fault_e;
endpackage

// File: rtl/wg_tick_window.sv
module wg_tick_window #(
  parameter int LIMIT = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last, cnt_en;

  always_comb begin
    at_last  = (cnt_q == LAST);
    expire_o = active_i && tick_i && at_last;
    cnt_en   = !active_i || (tick_i && !at_last);
    cnt_d    = active_i ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3/R4/R7: count saturates at the limit and restarts when the phase is left
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_clear_on_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> cnt_q == '0);
endmodule

// File: rtl/wg_trip.sv
module wg_trip
  import wg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alarm_i,
  input  logic       dry_i,
  input  logic       fill_to_i,
  input  logic       drain_to_i,
  input  logic       bump_i,
  input  logic       finish_i,
  output logic       off_o,
  output logic [2:0] code_o
);
  logic   off_q, off_d, hit, trip_en;
  fault_e code_q, code_d, pick;

  always_comb begin
    hit  = 1'b1;
    pick = FC_NONE;
    if (alarm_i)         pick = FC_ALARM;
    else if (dry_i)      pick = FC_DRY;
    else if (fill_to_i)  pick = FC_FILL_TO;
    else if (drain_to_i) pick = FC_DRAIN_TO;
    else if (bump_i)     pick = FC_BUMP;
    else if (finish_i)   pick = FC_NONE;
    else                 hit  = 1'b0;
    trip_en = hit && !off_q;
    off_d   = 1'b1;
    code_d  = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= 1'b0;
      code_q <= FC_NONE;
    end else if (trip_en) begin
      off_q  <= off_d;
      code_q <= code_d;
    end
  end

  assign off_o  = off_q;
  assign code_o = code_q;

  // R9: trip is sticky and the code frozen
  p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    off_o |=> off_o && $stable(code_o));
  // R8: alarm wins any same-cycle contest
  p_alarm_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !off_o && alarm_i |=> code_o == FC_ALARM);
  // R8: no water beats a coincident fill timeout
  p_dry_over_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !off_o && !alarm_i && dry_i && fill_to_i |=> code_o == FC_DRY);
  // R10: no code is held without a trip
  p_code_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !off_o |-> code_o == FC_NONE);
endmodule

// File: rtl/wash_fault_guard.sv
module wash_fault_guard
  import wg_pkg::*;
#(
  parameter int FILL_TICKS  = 300,
  parameter int DRAIN_TICKS = 200,
  parameter int CHIME_TICKS = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] phase_i,
  input  logic       tick_i,
  input  logic       level_hi_i,
  input  logic       supply_ok_i,
  input  logic       bump_i,
  input  logic       alarm_i,
  output logic       power_off_o,
  output logic [2:0] fault_o,
  output logic       chime_o
);
  logic rst_meta_n, rst_sync_n;
  logic in_fill, in_drain, in_spin, in_done;
  logic fill_exp, drain_exp, chime_exp;
  logic dry, fill_to, drain_to, bump_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  always_comb begin
    in_fill  = (phase_i == PH_FILL);
    in_drain = (phase_i == PH_DRAIN);
    in_spin  = (phase_i == PH_SPIN);
    in_done  = (phase_i == PH_DONE);
    dry      = in_fill && !supply_ok_i;
    fill_to  = fill_exp && !level_hi_i;
    drain_to = drain_exp && level_hi_i;
    bump_hit = in_spin && bump_i;
  end

  wg_tick_window #(.LIMIT(FILL_TICKS)) u_fill_win (
    .clk(clk), .rst_n(rst_sync_n), .active_i(in_fill), .tick_i(tick_i), .expire_o(fill_exp));

  wg_tick_window #(.LIMIT(DRAIN_TICKS)) u_drain_win (
    .clk(clk), .rst_n(rst_sync_n), .active_i(in_drain), .tick_i(tick_i), .expire_o(drain_exp));

  wg_tick_window #(.LIMIT(CHIME_TICKS)) u_chime_win (
    .clk(clk), .rst_n(rst_sync_n), .active_i(in_done), .tick_i(tick_i), .expire_o(chime_exp));

  wg_trip u_trip (
    .clk(clk), .rst_n(rst_sync_n),
    .alarm_i(alarm_i), .dry_i(dry), .fill_to_i(fill_to), .drain_to_i(drain_to),
    .bump_i(bump_hit), .finish_i(chime_exp),
    .off_o(power_off_o), .code_o(fault_o));

  assign chime_o = in_done && !power_off_o;

  // R1: alarm trips from any phase
  p_alarm_trip_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !power_off_o && alarm_i |=> power_off_o && fault_o == 3'd1);
  // R2: dry inlet during fill
  p_dry_trip_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !power_off_o && !alarm_i && phase_i == 3'd1 && !supply_ok_i |=> fault_o == 3'd2);
  // R5: drum contact during spin
  p_bump_trip_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !power_off_o && !alarm_i && phase_i == 3'd5 && bump_i |=> power_off_o && fault_o == 3'd5);
  // R7: chime never overlaps the cutoff
  p_chime_quiet_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chime_o |-> !power_off_o);
  // R10: outputs quiet while reset is held
  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_sync_n |-> !power_off_o && fault_o == 3'd0);
endmodule

// File: tb/wash_fault_guard_tb.sv
module wash_fault_guard_tb;
  localparam int FILL  = 6;
  localparam int DRAIN = 5;
  localparam int CHIME = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] phase;
  logic tick, level, supply, bump, alarm;
  logic power_off, chime;
  logic [2:0] fault;

  int n_chk = 0, n_fail = 0;
  int m_off, m_code, m_fill, m_drain, m_chime;
  bit finished = 0;

  always #2 clk = ~clk;

  wash_fault_guard #(.FILL_TICKS(FILL), .DRAIN_TICKS(DRAIN), .CHIME_TICKS(CHIME)) u_dut (
    .clk(clk), .rst_n(rst_n), .phase_i(phase), .tick_i(tick), .level_hi_i(level),
    .supply_ok_i(supply), .bump_i(bump), .alarm_i(alarm),
    .power_off_o(power_off), .fault_o(fault), .chime_o(chime));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int code);
    case (code)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R7";
    endcase
  endfunction

  // one clock: predict from requirements, advance, compare; returns at negedge
  task automatic step(input string tag);
    bit fe, de, ce, hit;
    int c;
    fe = (phase == 1) && tick && (m_fill == FILL - 1);
    de = (phase == 4) && tick && (m_drain == DRAIN - 1);
    ce = (phase == 6) && tick && (m_chime == CHIME - 1);
    hit = 1; c = 0;
    if (alarm)                    c = 1;
    else if (phase == 1 && !supply) c = 2;
    else if (fe && !level)        c = 3;
    else if (de && level)         c = 4;
    else if (phase == 5 && bump)  c = 5;
    else if (ce)                  c = 0;
    else                          hit = 0;
    if (hit && m_off == 0) begin m_off = 1; m_code = c; end
    m_fill  = (phase != 1) ? 0 : (tick && m_fill  != FILL - 1)  ? m_fill + 1  : m_fill;
    m_drain = (phase != 4) ? 0 : (tick && m_drain != DRAIN - 1) ? m_drain + 1 : m_drain;
    m_chime = (phase != 6) ? 0 : (tick && m_chime != CHIME - 1) ? m_chime + 1 : m_chime;
    @(posedge clk); #1;
    chk(tag, "power_off", power_off, m_off);
    chk(tag, "fault", fault, m_code);
    chk(tag, "chime", chime, (phase == 6 && m_off == 0) ? 1 : 0);
    @(negedge clk);
  endtask

  task automatic idle_in();
    phase = 3'd0; tick = 0; level = 0; supply = 1; bump = 0; alarm = 0;
  endtask

  task automatic do_reset();
    idle_in();
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    chk("R10", "power_off in reset", power_off, 0);
    chk("R10", "fault in reset", fault, 0);
    chk("R10", "chime in reset", chime, 0);
    m_off = 0; m_code = 0; m_fill = 0; m_drain = 0; m_chime = 0;
    rst_n = 1;
    repeat (3) step("R10");
  endtask

  task automatic set(input int ph, input bit tk, input bit lv, input bit sp, input bit bp, input bit al);
    phase = 3'(ph); tick = tk; level = lv; supply = sp; bump = bp; alarm = al;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    idle_in();
    rst_n = 0;
    @(negedge clk);
    do_reset();

    // R1: alarm while idle
    set(0, 0, 0, 1, 0, 1); step("R1");
    chk("R1", "alarm code", fault, 1);
    // R9: outputs hold while inputs wander
    set(5, 1, 1, 0, 1, 0); step("R9");
    set(6, 1, 0, 0, 0, 0); repeat (3) step("R9");
    chk("R9", "held code", fault, 1);
    do_reset();

    // R1: alarm during wash
    set(3, 1, 0, 1, 0, 1); step("R1");
    do_reset();

    // R2: dry inlet during fill
    set(1, 0, 0, 0, 0, 0); step("R2");
    chk("R2", "dry code", fault, 2);
    do_reset();

    // R6 and R11: dry inlet and bumps outside their phases are ignored
    set(3, 1, 0, 0, 1, 0); repeat (4) step("R6");
    set(2, 1, 1, 0, 1, 0); repeat (3) step("R11");
    set(7, 1, 1, 0, 1, 0); repeat (3) step("R11");
    chk("R6", "no trip", power_off, 0);
    // R5: bump ignored in drain (short), trips in spin
    set(4, 0, 0, 1, 1, 0); repeat (3) step("R5");
    chk("R5", "bump outside spin", power_off, 0);
    set(5, 0, 0, 1, 1, 0); step("R5");
    chk("R5", "bump code", fault, 5);
    do_reset();

    // R3: one tick short, leave, re-enter: no trip; then reach the limit
    set(1, 1, 0, 1, 0, 0); repeat (FILL - 1) step("R3");
    set(2, 1, 0, 1, 0, 0); step("R3");
    set(1, 1, 0, 1, 0, 0); repeat (FILL - 1) step("R3");
    chk("R3", "short of limit", power_off, 0);
    set(1, 0, 0, 1, 0, 0); repeat (4) step("R3");
    set(1, 1, 0, 1, 0, 0); step("R3");
    chk("R3", "fill timeout code", fault, 3);
    do_reset();
    // R3: level reached by the limit: no trip; later level drop still trips
    set(1, 1, 1, 1, 0, 0); repeat (FILL + 2) step("R3");
    chk("R3", "filled in time", power_off, 0);
    set(1, 1, 0, 1, 0, 0); step("R3");
    chk("R3", "late level loss", fault, 3);
    do_reset();

    // R4: drain limit
    set(4, 1, 1, 1, 0, 0); repeat (DRAIN - 1) step("R4");
    chk("R4", "short of drain limit", power_off, 0);
    step("R4");
    chk("R4", "drain timeout code", fault, 4);
    do_reset();
    set(4, 1, 0, 1, 0, 0); repeat (DRAIN + 3) step("R4");
    chk("R4", "drained in time", power_off, 0);
    do_reset();

    // R7: completion chime
    set(6, 1, 0, 1, 0, 0); step("R7");
    chk("R7", "chime on", chime, 1);
    repeat (CHIME - 2) step("R7");
    chk("R7", "chime before last tick", chime, 1);
    step("R7");
    chk("R7", "power off after chime", power_off, 1);
    chk("R7", "normal end code", fault, 0);
    chk("R7", "chime off", chime, 0);
    do_reset();

    // R8: same-cycle contests
    set(1, 0, 0, 0, 0, 1); step("R8");
    chk("R8", "alarm over dry", fault, 1);
    do_reset();
    set(1, 1, 0, 1, 0, 0); repeat (FILL - 1) step("R8");
    set(1, 1, 0, 0, 0, 0); step("R8");
    chk("R8", "dry over fill timeout", fault, 2);
    do_reset();
    set(6, 1, 0, 1, 0, 0); repeat (CHIME - 1) step("R8");
    set(6, 1, 0, 1, 0, 1); step("R8");
    chk("R8", "alarm over completion", fault, 1);
    do_reset();

    // randomised phase runs against the model
    for (int seg = 0; seg < 400; seg++) begin
      int ph, len;
      if (m_off != 0 && ($urandom % 3) != 0) do_reset();
      ph  = $urandom % 8;
      len = 1 + ($urandom % 24);
      for (int k = 0; k < len; k++) begin
        set(ph, ($urandom % 3) != 0, ($urandom % 4) == 0 ? ~level : level,
            ($urandom % 40) != 0, ($urandom % 12) == 0, ($urandom % 300) == 0);
        step(tag_of(m_code));
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule